// File: doc/BRIEF.md
# Eight-Stage Pipeline Operand Bypass Unit

This block chooses the operand values for an in-order pipeline with eight stages: IF, PR, ID, EX, MR, MW, WB and FW. The register file is read in PR and written in WB. That leaves a window in which a consumer can read a register before an older producer has written it. For each source operand held in ID and in EX, the unit compares the register number against the destination tags of the older instructions further down the pipe. It then reports a select code and the chosen operand value. It also raises a stall request when the nearest producer has not yet produced its result, for example a load still in flight.

The FW stage lives inside the unit. It is a one-cycle copy of the write-back destination, enable and value. It covers a producer and consumer five instructions apart: the consumer read the register file in PR in the same cycle the producer was writing it. None of the interfaces carries a data stream. Every pin is a plain per-stage tag or value, and the only back-pressure is the `stall` level, which the surrounding pipeline uses to hold ID and insert a bubble into EX.

Top module: `fwd_unit8`

## Requirements
- R1: While reset is asserted, the internal FW copy is cleared. In the first cycle after reset, an ID operand therefore never selects the FW path, whatever write-back was presented during reset.
- R2: An operand with no qualifying producer match passes through its base value with select code 0. For ID the base is the register-file value. For EX the base is the value carried from ID.
- R3: For an ID operand, the youngest qualifying producer wins. The order from youngest is MR, MW, WB, FW, and the select codes are 1, 2, 3 and 4 respectively. The output value is that producer's value.
- R4: A write-back presented in cycle t is forwarded to an ID operand in cycle t+1 with code 4, provided MR, MW and WB have no qualifying match in t+1.
- R5: An EX operand uses only the MR path (code 1) or, failing that, the WB path (code 3). It never reports code 2 or 4.
- R6: Register number zero never matches any producer, so it never forwards and never stalls.
- R7: A producer whose write-enable is low never matches, even when its destination tag equals the source.
- R8: `stall` is high exactly when, for either ID source, the youngest qualifying producer among EX and MR has its ready flag low. A ready match in EX hides an unready match in MR.
- R9: A non-load producer at any distance from 1 to 6 instructions ahead delivers its result to the consumer's EX operand. This holds when ID's chosen value is carried into EX and register-file reads happen before same-cycle writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the FW copy |
| id_rs | input | RIDX | First source register number in ID |
| id_rt | input | RIDX | Second source register number in ID |
| id_rs_rf | input | XLEN | Register-file value read in PR for id_rs |
| id_rt_rf | input | XLEN | Register-file value read in PR for id_rt |
| ex_rs | input | RIDX | First source register number in EX |
| ex_rt | input | RIDX | Second source register number in EX |
| ex_rs_in | input | XLEN | Operand value carried from ID for ex_rs |
| ex_rt_in | input | XLEN | Operand value carried from ID for ex_rt |
| ex_dst | input | RIDX | Destination register of the EX instruction |
| ex_we | input | 1 | EX instruction writes a register |
| ex_rdy | input | 1 | EX result will be available from MR next cycle |
| mr_dst | input | RIDX | Destination register of the MR instruction |
| mr_we | input | 1 | MR instruction writes a register |
| mr_rdy | input | 1 | MR result is valid now (low for a load in flight) |
| mr_val | input | XLEN | MR result value |
| mw_dst | input | RIDX | Destination register of the MW instruction |
| mw_we | input | 1 | MW instruction writes a register |
| mw_val | input | XLEN | MW result value |
| wb_dst | input | RIDX | Destination register being written back |
| wb_we | input | 1 | Write-back enable |
| wb_val | input | XLEN | Write-back value |
| id_rs_val | output | XLEN | Chosen value for id_rs |
| id_rt_val | output | XLEN | Chosen value for id_rt |
| ex_rs_val | output | XLEN | Chosen value for ex_rs |
| ex_rt_val | output | XLEN | Chosen value for ex_rt |
| id_rs_sel | output | 3 | Select code for id_rs (0 base, 1 MR, 2 MW, 3 WB, 4 FW) |
| id_rt_sel | output | 3 | Select code for id_rt |
| ex_rs_sel | output | 3 | Select code for ex_rs (0 base, 1 MR, 3 WB) |
| ex_rt_sel | output | 3 | Select code for ex_rt |
| stall | output | 1 | Hold ID and insert a bubble into EX |

## Verification
Select codes, operand values and `stall` are combinational in the stage inputs, so they are due in the same cycle the inputs are presented. The FW path is the exception: it responds one rising edge after the write-back it copies. The bench drives every input on the falling edge and samples 2 ns later, before the next rising edge. For FW cases it presents the write-back one full cycle before the vector under test. In the distance sweep, a bench-side register file and the ID-to-EX carry register both update only on the rising edge, with the read taken before the write. The EX operand is checked in the cycle the consumer sits in EX, which is distance plus three cycles after the producer enters IF.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int SEL_W = 3;
  typedef logic [SEL_W-1:0] sel_t;

  // Select codes reported per operand; ordering is youngest-first.
  localparam sel_t SEL_BASE = 3'd0;
  localparam sel_t SEL_MR   = 3'd1;
  localparam sel_t SEL_MW   = 3'd2;
  localparam sel_t SEL_WB   = 3'd3;
  localparam sel_t SEL_FW   = 3'd4;
endpackage

// File: rtl/fwd_hold.sv
// One-cycle copy of the write-back port: the FW stage.
module fwd_hold #(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RIDX-1:0] in_dst,
  input  logic            in_we,
  input  logic [XLEN-1:0] in_val,
  output logic [RIDX-1:0] out_dst,
  output logic            out_we,
  output logic [XLEN-1:0] out_val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_dst <= '0;
      out_we  <= 1'b0;
      out_val <= '0;
    end else begin
      out_dst <= in_dst;
      out_we  <= in_we;
      out_val <= in_val;
    end
  end
endmodule

// File: rtl/fwd_pick.sv
// Priority select of one source operand over NP producers; index 0 is youngest.
module fwd_pick
  import fwd_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RIDX = 5,
  parameter int NP   = 4,
  parameter logic [NP-1:0][SEL_W-1:0] CODES = '0
) (
  input  logic [RIDX-1:0]          src,
  input  logic [XLEN-1:0]          base,
  input  logic [NP-1:0][RIDX-1:0]  p_dst,
  input  logic [NP-1:0]            p_we,
  input  logic [NP-1:0][XLEN-1:0]  p_val,
  output logic [XLEN-1:0]          val,
  output sel_t                     sel
);
  logic [NP-1:0] hit;

  always_comb begin
    for (int i = 0; i < NP; i++)
      hit[i] = p_we[i] && (src != '0) && (p_dst[i] == src);
  end

  // Walk from oldest to youngest so the youngest hit overwrites last.
  always_comb begin
    val = base;
    sel = SEL_BASE;
    for (int i = NP-1; i >= 0; i--) begin
      if (hit[i]) begin
        val = p_val[i];
        sel = CODES[i];
      end
    end
  end
endmodule

// File: rtl/fwd_stall.sv
// Stall decision for one ID source: nearest producer among EX and MR decides.
module fwd_stall #(
  parameter int RIDX = 5
) (
  input  logic [RIDX-1:0] src,
  input  logic [RIDX-1:0] ex_dst,
  input  logic            ex_we,
  input  logic            ex_rdy,
  input  logic [RIDX-1:0] mr_dst,
  input  logic            mr_we,
  input  logic            mr_rdy,
  output logic            need
);
  logic ex_hit, mr_hit;

  assign ex_hit = ex_we && (src != '0) && (ex_dst == src);
  assign mr_hit = mr_we && (src != '0) && (mr_dst == src);

  always_comb begin
    if (ex_hit)      need = !ex_rdy;
    else if (mr_hit) need = !mr_rdy;
    else             need = 1'b0;
  end
endmodule

// File: rtl/fwd_unit8.sv
module fwd_unit8
  import fwd_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RIDX-1:0] id_rs,
  input  logic [RIDX-1:0] id_rt,
  input  logic [XLEN-1:0] id_rs_rf,
  input  logic [XLEN-1:0] id_rt_rf,
  input  logic [RIDX-1:0] ex_rs,
  input  logic [RIDX-1:0] ex_rt,
  input  logic [XLEN-1:0] ex_rs_in,
  input  logic [XLEN-1:0] ex_rt_in,
  input  logic [RIDX-1:0] ex_dst,
  input  logic            ex_we,
  input  logic            ex_rdy,
  input  logic [RIDX-1:0] mr_dst,
  input  logic            mr_we,
  input  logic            mr_rdy,
  input  logic [XLEN-1:0] mr_val,
  input  logic [RIDX-1:0] mw_dst,
  input  logic            mw_we,
  input  logic [XLEN-1:0] mw_val,
  input  logic [RIDX-1:0] wb_dst,
  input  logic            wb_we,
  input  logic [XLEN-1:0] wb_val,
  output logic [XLEN-1:0] id_rs_val,
  output logic [XLEN-1:0] id_rt_val,
  output logic [XLEN-1:0] ex_rs_val,
  output logic [XLEN-1:0] ex_rt_val,
  output logic [SEL_W-1:0] id_rs_sel,
  output logic [SEL_W-1:0] id_rt_sel,
  output logic [SEL_W-1:0] ex_rs_sel,
  output logic [SEL_W-1:0] ex_rt_sel,
  output logic            stall
);
  localparam int NOPS  = 2;  // source operands per stage
  localparam int NP_ID = 4;  // MR, MW, WB, FW
  localparam int NP_EX = 2;  // MR, WB
  localparam logic [NP_ID-1:0][SEL_W-1:0] ID_CODES = {SEL_FW, SEL_WB, SEL_MW, SEL_MR};
  localparam logic [NP_EX-1:0][SEL_W-1:0] EX_CODES = {SEL_WB, SEL_MR};

  // FW stage
  logic [RIDX-1:0] fw_dst;
  logic            fw_we;
  logic [XLEN-1:0] fw_val;

  fwd_hold #(.XLEN(XLEN), .RIDX(RIDX)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_dst  (wb_dst),
    .in_we   (wb_we),
    .in_val  (wb_val),
    .out_dst (fw_dst),
    .out_we  (fw_we),
    .out_val (fw_val)
  );

  // Producer tables, youngest at index 0
  logic [NP_ID-1:0][RIDX-1:0] idp_dst;
  logic [NP_ID-1:0]           idp_we;
  logic [NP_ID-1:0][XLEN-1:0] idp_val;
  logic [NP_EX-1:0][RIDX-1:0] exp_dst;
  logic [NP_EX-1:0]           exp_we;
  logic [NP_EX-1:0][XLEN-1:0] exp_val;

  assign idp_dst = {fw_dst, wb_dst, mw_dst, mr_dst};
  assign idp_we  = {fw_we,  wb_we,  mw_we,  mr_we};
  assign idp_val = {fw_val, wb_val, mw_val, mr_val};
  assign exp_dst = {wb_dst, mr_dst};
  assign exp_we  = {wb_we,  mr_we};
  assign exp_val = {wb_val, mr_val};

  // Operand tables, index 0 = rs, 1 = rt
  logic [NOPS-1:0][RIDX-1:0] id_src, ex_src;
  logic [NOPS-1:0][XLEN-1:0] id_base, ex_base, id_res, ex_res;
  sel_t [NOPS-1:0]           id_code, ex_code;
  logic [NOPS-1:0]           need;

  assign id_src  = {id_rt, id_rs};
  assign ex_src  = {ex_rt, ex_rs};
  assign id_base = {id_rt_rf, id_rs_rf};
  assign ex_base = {ex_rt_in, ex_rs_in};

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    fwd_pick #(.XLEN(XLEN), .RIDX(RIDX), .NP(NP_ID), .CODES(ID_CODES)) u_id_pick (
      .src   (id_src[g]),
      .base  (id_base[g]),
      .p_dst (idp_dst),
      .p_we  (idp_we),
      .p_val (idp_val),
      .val   (id_res[g]),
      .sel   (id_code[g])
    );

    fwd_pick #(.XLEN(XLEN), .RIDX(RIDX), .NP(NP_EX), .CODES(EX_CODES)) u_ex_pick (
      .src   (ex_src[g]),
      .base  (ex_base[g]),
      .p_dst (exp_dst),
      .p_we  (exp_we),
      .p_val (exp_val),
      .val   (ex_res[g]),
      .sel   (ex_code[g])
    );

    fwd_stall #(.RIDX(RIDX)) u_stall (
      .src    (id_src[g]),
      .ex_dst (ex_dst),
      .ex_we  (ex_we),
      .ex_rdy (ex_rdy),
      .mr_dst (mr_dst),
      .mr_we  (mr_we),
      .mr_rdy (mr_rdy),
      .need   (need[g])
    );
  end

  assign id_rs_val = id_res[0];
  assign id_rt_val = id_res[1];
  assign ex_rs_val = ex_res[0];
  assign ex_rt_val = ex_res[1];
  assign id_rs_sel = id_code[0];
  assign id_rt_sel = id_code[1];
  assign ex_rs_sel = ex_code[0];
  assign ex_rt_sel = ex_code[1];
  assign stall     = |need;
endmodule

// File: rtl/fwd_unit8_chk.sv
module fwd_unit8_chk #(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [RIDX-1:0] id_rs,
  input logic [RIDX-1:0] ex_dst,
  input logic            ex_we,
  input logic            ex_rdy,
  input logic [RIDX-1:0] mr_dst,
  input logic            mr_we,
  input logic [XLEN-1:0] mr_val,
  input logic [RIDX-1:0] mw_dst,
  input logic            mw_we,
  input logic [RIDX-1:0] wb_dst,
  input logic            wb_we,
  input logic [XLEN-1:0] wb_val,
  input logic [XLEN-1:0] id_rs_val,
  input logic [2:0]      id_rs_sel,
  input logic [2:0]      ex_rs_sel,
  input logic            stall
);
  a_r6_zero_never_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs == '0) |-> (id_rs_sel == 3'd0));

  a_r3_mr_youngest: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_we && mr_dst == id_rs && id_rs != '0) |-> (id_rs_sel == 3'd1 && id_rs_val == mr_val));

  a_r7_mr_needs_we: assert property (@(posedge clk) disable iff (!rst_n)
    (!mr_we) |-> (id_rs_sel != 3'd1));

  a_r5_ex_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs_sel != 3'd2) && (ex_rs_sel != 3'd4));

  a_r4_fw_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wb_we) && $past(wb_dst) == id_rs && id_rs != '0 &&
     !(mr_we && mr_dst == id_rs) && !(mw_we && mw_dst == id_rs) && !(wb_we && wb_dst == id_rs))
    |-> (id_rs_sel == 3'd4 && id_rs_val == $past(wb_val)));

  a_r8_ex_unready_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_we && ex_dst == id_rs && id_rs != '0 && !ex_rdy) |-> stall);
endmodule

bind fwd_unit8 fwd_unit8_chk #(.XLEN(XLEN), .RIDX(RIDX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .id_rs     (id_rs),
  .ex_dst    (ex_dst),
  .ex_we     (ex_we),
  .ex_rdy    (ex_rdy),
  .mr_dst    (mr_dst),
  .mr_we     (mr_we),
  .mr_val    (mr_val),
  .mw_dst    (mw_dst),
  .mw_we     (mw_we),
  .wb_dst    (wb_dst),
  .wb_we     (wb_we),
  .wb_val    (wb_val),
  .id_rs_val (id_rs_val),
  .id_rs_sel (id_rs_sel),
  .ex_rs_sel (ex_rs_sel),
  .stall     (stall)
);

// File: tb/fwd_unit8_tb_top.sv
`timescale 1ns/1ps
module fwd_unit8_tb_top;
  localparam int XLEN = 32;
  localparam int RIDX = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [RIDX-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_dst, mr_dst, mw_dst, wb_dst;
  logic [XLEN-1:0] id_rs_rf, id_rt_rf, ex_rs_in, ex_rt_in, mr_val, mw_val, wb_val;
  logic            ex_we, ex_rdy, mr_we, mr_rdy, mw_we, wb_we;
  logic [XLEN-1:0] id_rs_val, id_rt_val, ex_rs_val, ex_rt_val;
  logic [2:0]      id_rs_sel, id_rt_sel, ex_rs_sel, ex_rt_sel;
  logic            stall;

  fwd_unit8 #(.XLEN(XLEN), .RIDX(RIDX)) dut_i (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    id_rs = '0; id_rt = '0; id_rs_rf = '0; id_rt_rf = '0;
    ex_rs = '0; ex_rt = '0; ex_rs_in = '0; ex_rt_in = '0;
    ex_dst = '0; ex_we = 0; ex_rdy = 1;
    mr_dst = '0; mr_we = 0; mr_rdy = 1; mr_val = '0;
    mw_dst = '0; mw_we = 0; mw_val = '0;
    wb_dst = '0; wb_we = 0; wb_val = '0;
  endtask

  // Watchdog
  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [RIDX-1:0] tg;
    logic [XLEN-1:0] vmr, vmw, vwb, vfw, base, exb, exp_v;
    logic [2:0]      exp_s;
    logic            exp_st;
    bit              eff [5];
    string           tag;
    logic [XLEN-1:0] rf9, id_rf_m, ex_in_m, vd, id_smp;

    idle();
    // R1: write-back presented during reset must not leak into FW.
    wb_dst = 5'd7; wb_we = 1; wb_val = 32'h5151_5151;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    idle();
    id_rs = 5'd7; id_rs_rf = 32'h0000_0777;
    #2;
    check("R1 id_rs_sel after reset", 32'(id_rs_sel), 32'd0);
    check("R1 id_rs_val after reset", id_rs_val, 32'h0000_0777);
    check("R1 stall after reset", 32'(stall), 32'd0);

    // Near-exhaustive sweep: match mask over EX,MR,MW,WB,FW x ready x gating.
    for (int t = 0; t < 2; t++)
      for (int m = 0; m < 32; m++)
        for (int r = 0; r < 4; r++)
          for (int k = 0; k < 2; k++) begin
            tg  = (t != 0) ? 5'd7 : 5'd0;
            vmr = 32'h1100_0000 + 32'(m * 8 + r * 2 + k);
            vmw = 32'h2200_0000 + 32'(m * 8 + r * 2 + k);
            vwb = 32'h3300_0000 + 32'(m * 8 + r * 2 + k);
            vfw = 32'h4400_0000 + 32'(m * 8 + r * 2 + k);
            base = 32'hBA5E_0000 + 32'(m);
            exb  = 32'hCAFE_0000 + 32'(m);
            for (int b = 0; b < 5; b++) eff[b] = m[b] && (tg != '0) && (k == 0);

            // Cycle A: write-back that becomes the FW entry
            @(negedge clk);
            idle();
            if (m[4]) begin wb_dst = tg; wb_we = (k == 0); end
            else begin wb_dst = 5'd12; wb_we = 1; end
            wb_val = vfw;

            // Cycle B: vector under test
            @(negedge clk);
            idle();
            id_rs = tg; id_rs_rf = base; id_rt = 5'd3; id_rt_rf = 32'h0000_7777;
            ex_rs = tg; ex_rs_in = exb;  ex_rt = 5'd3; ex_rt_in = 32'h0000_8888;
            ex_rdy = r[0]; mr_rdy = r[1];
            ex_dst = m[0] ? tg : 5'd12; ex_we = m[0] ? (k == 0) : 1'b1;
            mr_dst = m[1] ? tg : 5'd12; mr_we = m[1] ? (k == 0) : 1'b1; mr_val = vmr;
            mw_dst = m[2] ? tg : 5'd12; mw_we = m[2] ? (k == 0) : 1'b1; mw_val = vmw;
            wb_dst = m[3] ? tg : 5'd12; wb_we = m[3] ? (k == 0) : 1'b1; wb_val = vwb;
            #2;

            if (tg == '0) tag = "R6";
            else if (k != 0) tag = "R7";
            else tag = "R3";

            if (eff[1])      begin exp_s = 3'd1; exp_v = vmr; end
            else if (eff[2]) begin exp_s = 3'd2; exp_v = vmw; end
            else if (eff[3]) begin exp_s = 3'd3; exp_v = vwb; end
            else if (eff[4]) begin exp_s = 3'd4; exp_v = vfw; tag = "R4"; end
            else             begin exp_s = 3'd0; exp_v = base; end
            check({tag, " id_rs_sel"}, 32'(id_rs_sel), 32'(exp_s));
            check({tag, " id_rs_val"}, id_rs_val, exp_v);

            if (eff[1])      begin exp_s = 3'd1; exp_v = vmr; end
            else if (eff[3]) begin exp_s = 3'd3; exp_v = vwb; end
            else             begin exp_s = 3'd0; exp_v = exb; end
            check("R5 ex_rs_sel", 32'(ex_rs_sel), 32'(exp_s));
            check("R5 ex_rs_val", ex_rs_val, exp_v);

            check("R2 id_rt_val", id_rt_val, 32'h0000_7777);
            check("R2 id_rt_sel", 32'(id_rt_sel), 32'd0);
            check("R2 ex_rt_val", ex_rt_val, 32'h0000_8888);

            if (eff[0])      exp_st = !r[0];
            else if (eff[1]) exp_st = !r[1];
            else             exp_st = 1'b0;
            check("R8 stall", 32'(stall), 32'(exp_st));
          end

    // R9: end-to-end distance sweep, producer = instr 0 writing r9, consumer = instr d.
    for (int d = 1; d <= 6; d++) begin
      @(negedge clk); idle();
      @(negedge clk); idle();
      rf9 = 32'hDEAD_0000; id_rf_m = '0; ex_in_m = '0;
      vd = 32'h9900_0000 + 32'(d);
      for (int c = 0; c <= d + 3; c++) begin
        if (c > 0) @(negedge clk);
        idle();
        id_rs = (c - 2 == d) ? 5'd9 : 5'd0; id_rs_rf = id_rf_m;
        ex_rs = (c - 3 == d) ? 5'd9 : 5'd0; ex_rs_in = ex_in_m;
        if (c == 3) begin ex_dst = 5'd9; ex_we = 1; end
        if (c == 4) begin mr_dst = 5'd9; mr_we = 1; mr_val = vd; end
        if (c == 5) begin mw_dst = 5'd9; mw_we = 1; mw_val = vd; end
        if (c == 6) begin wb_dst = 5'd9; wb_we = 1; wb_val = vd; end
        #2;
        id_smp = id_rs_val;
        if (c == d + 3) check($sformatf("R9 distance %0d ex_rs_val", d), ex_rs_val, vd);
        @(posedge clk);
        // register updates: read before same-cycle write
        if (c - 1 == d) id_rf_m = rf9;
        if (c - 2 == d) ex_in_m = id_smp;
        if (c == 6) rf9 = vd;
      end
    end

    // R8: load one ahead (unready in EX) stalls a dependent ID source.
    @(negedge clk); idle();
    id_rt = 5'd4; ex_dst = 5'd4; ex_we = 1; ex_rdy = 0;
    #2;
    check("R8 load-use stall via id_rt", 32'(stall), 32'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule